// File: doc/BRIEF.md
# Per-Address Memory Operation Queues

This unit sits between one in-order issuing thread and the memory side of a weakly ordered memory model. Every load or store the thread issues is placed in a FIFO owned by its target location. There are separate queue sets for the shared region and the global region. Accesses to one location therefore leave in program order, while accesses to different locations may leave in any order. A drain-select input stands in for the free choice of which queue empties next. An accepted drain request presents the oldest operation of the chosen queue on a memory-side port.

A fence drops a marker, tagged with its scope (block or device), into every queue in the same cycle. A marker blocks its queue until every queue has a marker at its head. All heads are then markers of the same fence, and they retire together. The retirement is signalled on a fence-complete output with the scope. A program counter counts the accepted operations.

Top module: `memop_addr_queues`

## Requirements
- R1: After reset every queue is empty, the program counter is 0, issue_ready is 1, fence_done is 0, and a drain request to any queue is a no-op.
- R2: A load or store is appended only to queue index {issue_region, issue_addr}, where region 0 is shared and region 1 is global. No other queue changes.
- R3: A drain request whose selected queue has a load or store at its head sets mem_valid for that cycle. In the same cycle it shows the head's store flag and data, with mem_region and mem_addr taken from drain_sel, and it removes that head at the clock edge.
- R4: Operations to the same queue drain in the order they were issued. Queues may be drained in any order the drain select chooses.
- R5: An accepted fence appends one marker carrying issue_scope (0 block, 1 device) to every queue in the same cycle.
- R6: When every queue is non-empty with a fence marker at its head, fence_done is 1 and fence_scope gives that marker's scope. All of those markers are removed at that clock edge.
- R7: A drain request that selects an empty queue, or a queue whose head is a fence marker, raises drain_noop, keeps mem_valid at 0 and removes nothing.
- R8: Every accepted issue (issue_valid and issue_ready) advances the program counter by one, wrapping modulo 2^PC_W. Fences count as issues.
- R9: issue_ready is 0 when a load or store targets a full queue, or when a fence is offered while any queue is full. A refused operation changes no queue and leaves the program counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Thread offers an operation |
| issue_is_fence | input | 1 | Operation is a fence (overrides store flag) |
| issue_is_store | input | 1 | 1 store, 0 load |
| issue_region | input | 1 | 0 shared, 1 global |
| issue_addr | input | ADDR_W | Location within the region |
| issue_data | input | DATA_W | Store value carried with the access |
| issue_scope | input | 1 | Fence scope: 0 block, 1 device |
| issue_ready | output | 1 | Operation accepted this cycle when valid |
| pc | output | PC_W | Count of accepted operations |
| drain_valid | input | 1 | Memory side asks for one queue head |
| drain_sel | input | ADDR_W+1 | Queue index {region, addr} to drain |
| mem_valid | output | 1 | A load or store leaves this cycle |
| mem_is_store | output | 1 | Departing access is a store |
| mem_region | output | 1 | Region of departing access |
| mem_addr | output | ADDR_W | Location of departing access |
| mem_data | output | DATA_W | Data of departing access |
| drain_noop | output | 1 | Drain request ignored this cycle |
| fence_done | output | 1 | A fence retires from all queues this cycle |
| fence_scope | output | 1 | Scope of the retiring fence |

## Verification
The bench fills every queue to its depth with alternating loads and stores and then drains the queues in reverse index order. A design that routed by the wrong index bits, or that lost per-queue order, would return data from the wrong location or in the wrong sequence. Fences are issued while some queues are still empty and others still hold older accesses. This exposes a marker that retires before all queues reach it, a drain that slips past a marker, and a drain of a marker that is not flagged as a no-op. Full-queue stalls are checked for both kinds of issue, since a fence must be held back when any single queue is full. A long pseudo-random mix checks the program counter through several wraps against a reference model built from the requirements.

// File: rtl/mq_pkg.sv
package mq_pkg;
   typedef struct packed {
      logic fence;
      logic store;
      logic scope;
   } mq_tag_t;

   localparam int unsigned TAG_W = $bits(mq_tag_t);
endpackage

// File: rtl/mq_fifo.sv
module mq_fifo #(
   parameter int unsigned W     = 11,
   parameter int unsigned DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("mq_fifo: DEPTH must be a power of two and at least 2");
   end

   logic [W-1:0] store_q [DEPTH];
   logic [AW:0]  wr_q, rd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q <= '0;
         rd_q <= '0;
      end else begin
         if (push) wr_q <= wr_q + 1'b1;
         if (pop)  rd_q <= rd_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push) store_q[wr_q[AW-1:0]] <= din;
   end

   assign dout  = store_q[rd_q[AW-1:0]];
   assign empty = (wr_q == rd_q);
   assign full  = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full); // R9
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty); // R7
endmodule

// File: rtl/mq_head_sel.sv
module mq_head_sel
   import mq_pkg::*;
#(
   parameter int unsigned NQ     = 4,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned W     = DATA_W + TAG_W,
   localparam int unsigned QW    = $clog2(NQ)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NQ-1:0][W-1:0]  heads,
   input  logic [NQ-1:0]         empty,
   input  logic                  drain_valid,
   input  logic [QW-1:0]         drain_sel,
   output logic [NQ-1:0]         pop_drain,
   output logic                  take,
   output logic                  noop,
   output logic                  sel_store,
   output logic [DATA_W-1:0]     sel_data,
   output logic                  all_fence,
   output logic                  fence_scope
);
   mq_tag_t       sel_tag;
   mq_tag_t       tags [NQ];
   logic [NQ-1:0] scopes;

   always_comb begin
      all_fence = 1'b1;
      for (int i = 0; i < NQ; i++) begin
         tags[i]   = mq_tag_t'(heads[i][W-1 -: TAG_W]);
         scopes[i] = tags[i].scope;
         all_fence = all_fence & !empty[i] & tags[i].fence;
      end
      fence_scope = tags[0].scope;
   end

   always_comb begin
      sel_tag   = mq_tag_t'(heads[drain_sel][W-1 -: TAG_W]);
      sel_data  = heads[drain_sel][DATA_W-1:0];
      sel_store = sel_tag.store;
      take      = drain_valid && !empty[drain_sel] && !sel_tag.fence;
      noop      = drain_valid && !take;
      for (int i = 0; i < NQ; i++) begin
         pop_drain[i] = take && (drain_sel == QW'(i));
      end
   end

   AST_FENCE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      all_fence |-> ($countones(scopes) == 0 || $countones(scopes) == NQ)); // R6
endmodule

// File: rtl/memop_addr_queues.sv
module memop_addr_queues
   import mq_pkg::*;
#(
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned PC_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_valid,
   input  logic              issue_is_fence,
   input  logic              issue_is_store,
   input  logic              issue_region,
   input  logic [ADDR_W-1:0] issue_addr,
   input  logic [DATA_W-1:0] issue_data,
   input  logic              issue_scope,
   output logic              issue_ready,
   output logic [PC_W-1:0]   pc,
   input  logic              drain_valid,
   input  logic [ADDR_W:0]   drain_sel,
   output logic              mem_valid,
   output logic              mem_is_store,
   output logic              mem_region,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_data,
   output logic              drain_noop,
   output logic              fence_done,
   output logic              fence_scope
);
   localparam int unsigned QW = ADDR_W + 1;
   localparam int unsigned NQ = 1 << QW;
   localparam int unsigned W  = DATA_W + TAG_W;

   if (ADDR_W < 1 || ADDR_W > 6) begin : g_bad_addr
      $error("memop_addr_queues: ADDR_W must lie in 1..6");
   end
   if (DATA_W < 1 || PC_W < 1) begin : g_bad_width
      $error("memop_addr_queues: DATA_W and PC_W must be positive");
   end

   logic [QW-1:0]        tgt;
   logic [NQ-1:0]        q_full, q_empty, q_push, q_pop, pop_drain;
   logic [NQ-1:0][W-1:0] q_head;
   logic [W-1:0]         new_entry;
   mq_tag_t              new_tag;
   logic                 accept, all_fence, take;
   logic [PC_W-1:0]      pc_q;

   assign tgt = {issue_region, issue_addr};

   always_comb begin
      new_tag.fence = issue_is_fence;
      new_tag.store = issue_is_store && !issue_is_fence;
      new_tag.scope = issue_scope;
      new_entry     = {new_tag, issue_data};
      issue_ready   = issue_is_fence ? !(|q_full) : !q_full[tgt];
      accept        = issue_valid && issue_ready;
   end

   for (genvar g = 0; g < NQ; g++) begin : g_queue
      assign q_push[g] = accept && (issue_is_fence || tgt == QW'(g));
      assign q_pop[g]  = pop_drain[g] || all_fence;

      mq_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
         .clk   (clk),
         .rst_n (rst_n),
         .push  (q_push[g]),
         .din   (new_entry),
         .pop   (q_pop[g]),
         .dout  (q_head[g]),
         .empty (q_empty[g]),
         .full  (q_full[g])
      );
   end

   mq_head_sel #(.NQ(NQ), .DATA_W(DATA_W)) u_head_sel (
      .clk         (clk),
      .rst_n       (rst_n),
      .heads       (q_head),
      .empty       (q_empty),
      .drain_valid (drain_valid),
      .drain_sel   (drain_sel),
      .pop_drain   (pop_drain),
      .take        (take),
      .noop        (drain_noop),
      .sel_store   (mem_is_store),
      .sel_data    (mem_data),
      .all_fence   (all_fence),
      .fence_scope (fence_scope)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) pc_q <= '0;
      else if (accept) pc_q <= pc_q + 1'b1;
   end

   assign pc         = pc_q;
   assign mem_valid  = take;
   assign mem_region = drain_sel[QW-1];
   assign mem_addr   = drain_sel[ADDR_W-1:0];
   assign fence_done = all_fence;

   AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_ready) |=> pc == $past(pc) + PC_W'(1)); // R8
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && !issue_ready) |=> pc == $past(pc)); // R9
   AST_DRAIN_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      drain_valid |-> (mem_valid ^ drain_noop)); // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !drain_valid |-> !(mem_valid || drain_noop)); // R3
endmodule

// File: tb/memop_addr_queues_bench.sv
module memop_addr_queues_bench;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 1;
   localparam int DATA_W = 8;
   localparam int DEPTH  = 4;
   localparam int PC_W   = 4;
   localparam int QW     = ADDR_W + 1;
   localparam int NQ     = 1 << QW;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              issue_valid = 1'b0, issue_is_fence = 1'b0, issue_is_store = 1'b0;
   logic              issue_region = 1'b0, issue_scope = 1'b0;
   logic [ADDR_W-1:0] issue_addr = '0;
   logic [DATA_W-1:0] issue_data = '0;
   logic              issue_ready;
   logic [PC_W-1:0]   pc;
   logic              drain_valid = 1'b0;
   logic [QW-1:0]     drain_sel = '0;
   logic              mem_valid, mem_is_store, mem_region, drain_noop, fence_done, fence_scope;
   logic [ADDR_W-1:0] mem_addr;
   logic [DATA_W-1:0] mem_data;

   int checks = 0;
   int errors = 0;

   // reference model: entry = {fence, store, scope, data}
   logic [DATA_W+2:0] mq [NQ][DEPTH];
   int                cnt [NQ];
   int                exp_pc = 0;
   logic [15:0]       lfsr = 16'hACE1;

   always #(CLK_PERIOD/2) clk = ~clk;

   memop_addr_queues #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .PC_W(PC_W)) u_memop_addr_queues (
      .clk(clk), .rst_n(rst_n),
      .issue_valid(issue_valid), .issue_is_fence(issue_is_fence), .issue_is_store(issue_is_store),
      .issue_region(issue_region), .issue_addr(issue_addr), .issue_data(issue_data),
      .issue_scope(issue_scope), .issue_ready(issue_ready), .pc(pc),
      .drain_valid(drain_valid), .drain_sel(drain_sel),
      .mem_valid(mem_valid), .mem_is_store(mem_is_store), .mem_region(mem_region),
      .mem_addr(mem_addr), .mem_data(mem_data), .drain_noop(drain_noop),
      .fence_done(fence_done), .fence_scope(fence_scope)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit head_fence(input int q);
      return cnt[q] > 0 && mq[q][0][DATA_W+2];
   endfunction

   task automatic cyc(input bit iv, input bit ifn, input bit ist, input int iq,
                      input logic [DATA_W-1:0] id, input bit isc, input bit dv, input int ds);
      bit exp_ready, all_f, exp_take;
      bit pops [NQ];
      issue_valid = iv; issue_is_fence = ifn; issue_is_store = ist;
      issue_region = iq[QW-1]; issue_addr = iq[ADDR_W-1:0];
      issue_data = id; issue_scope = isc;
      drain_valid = dv; drain_sel = ds[QW-1:0];
      #(CLK_PERIOD/4);
      exp_ready = 1'b1;
      if (ifn) begin
         for (int q = 0; q < NQ; q++) if (cnt[q] == DEPTH) exp_ready = 1'b0;
      end else if (cnt[iq] == DEPTH) exp_ready = 1'b0;
      if (iv) check(issue_ready == exp_ready, "R9 issue_ready", issue_ready, exp_ready);
      all_f = 1'b1;
      for (int q = 0; q < NQ; q++) if (!head_fence(q)) all_f = 1'b0;
      check(fence_done == all_f, "R6 fence_done", fence_done, all_f);
      if (all_f) check(fence_scope == mq[0][0][DATA_W], "R6 fence_scope", fence_scope, mq[0][0][DATA_W]);
      exp_take = dv && cnt[ds] > 0 && !mq[ds][0][DATA_W+2];
      check(mem_valid == exp_take, "R3 mem_valid", mem_valid, exp_take);
      check(drain_noop == (dv && !exp_take), "R7 drain_noop", drain_noop, dv && !exp_take);
      if (exp_take) begin
         check(mem_data == mq[ds][0][DATA_W-1:0], "R4 mem_data order", mem_data, mq[ds][0][DATA_W-1:0]);
         check(mem_is_store == mq[ds][0][DATA_W+1], "R3 mem_is_store", mem_is_store, mq[ds][0][DATA_W+1]);
         check({mem_region, mem_addr} == ds[QW-1:0], "R2 mem location", {mem_region, mem_addr}, ds);
      end
      @(posedge clk);
      for (int q = 0; q < NQ; q++) pops[q] = all_f || (exp_take && q == ds);
      for (int q = 0; q < NQ; q++) begin
         if (pops[q]) begin
            for (int i = 0; i < DEPTH-1; i++) mq[q][i] = mq[q][i+1];
            cnt[q]--;
         end
      end
      if (iv && exp_ready) begin
         for (int q = 0; q < NQ; q++) begin
            if (ifn || q == iq) begin
               mq[q][cnt[q]] = {ifn, ist && !ifn, isc, id};
               cnt[q]++;
            end
         end
         exp_pc = (exp_pc + 1) % (1 << PC_W);
      end
      @(negedge clk);
      check(pc == exp_pc[PC_W-1:0], "R8 pc", pc, exp_pc);
   endtask

   initial begin
      for (int q = 0; q < NQ; q++) cnt[q] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #(CLK_PERIOD/4);
      check(pc == 0, "R1 pc reset", pc, 0);
      check(issue_ready == 1'b1, "R1 ready reset", issue_ready, 1);
      check(fence_done == 1'b0, "R1 fence_done reset", fence_done, 0);
      @(negedge clk);
      // R1/R7: every queue empty after reset
      for (int q = 0; q < NQ; q++) cyc(0, 0, 0, 0, 8'h00, 0, 1, q);
      // R2/R4/R9: fill each queue past its depth, alternating loads and stores
      for (int q = 0; q < NQ; q++)
         for (int k = 0; k <= DEPTH; k++) cyc(1, 0, k[0], q, 8'(q*16 + k), 0, 0, 0);
      for (int q = NQ-1; q >= 0; q--)
         for (int k = 0; k <= DEPTH; k++) cyc(0, 0, 0, 0, 8'h00, 0, 1, q);
      // R5/R6/R7: fence behind older accesses in some queues
      cyc(1, 0, 1, 0, 8'hA0, 0, 0, 0);
      cyc(1, 0, 0, 1, 8'hA1, 0, 0, 0);
      cyc(1, 1, 0, 0, 8'h00, 1, 0, 0);
      cyc(1, 0, 0, 2, 8'hA2, 0, 0, 0);
      cyc(0, 0, 0, 0, 8'h00, 0, 1, 2);
      cyc(0, 0, 0, 0, 8'h00, 0, 1, 0);
      cyc(0, 0, 0, 0, 8'h00, 0, 1, 1);
      cyc(0, 0, 0, 0, 8'h00, 0, 1, 3);
      cyc(0, 0, 0, 0, 8'h00, 0, 1, 2);
      cyc(1, 1, 0, 0, 8'h00, 0, 0, 0);
      cyc(0, 0, 0, 0, 8'h00, 0, 1, 3);
      // R9: fence refused while one queue is full
      for (int k = 0; k < DEPTH; k++) cyc(1, 0, 1, 3, 8'(8'hC0 + k), 0, 0, 0);
      cyc(1, 1, 0, 0, 8'h00, 1, 0, 0);
      cyc(1, 0, 1, 1, 8'hB1, 0, 0, 0);
      for (int k = 0; k < DEPTH; k++) cyc(0, 0, 0, 0, 8'h00, 0, 1, 3);
      cyc(0, 0, 0, 0, 8'h00, 0, 1, 1);
      // mixed traffic, all requirements against the model
      for (int n = 0; n < 800; n++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         cyc(lfsr[0], lfsr[3:1] == 3'd0, lfsr[4], int'(lfsr[6:5]), lfsr[14:7], lfsr[15],
             lfsr[8] | lfsr[9], int'(lfsr[11:10]));
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule